// File: doc/BRIEF.md
# Serial Port Clock and Frame Sync Selector

This block sits between the pins of a synchronous serial port and its receive and transmit shift logic. For each direction it decides where the bit clock and the frame sync come from: the external pin, or the internal sample-rate generator whose clock and sync arrive as inputs. When a direction sources a signal internally, the block drives that pin and asserts its output enable. A polarity control on each of the four pin paths inverts the signal, so the shift logic always sees an active-high frame sync whatever the board uses.

All logic runs on the system clock. The serial clocks are treated as sampled levels. External pins pass through a two-stage synchronizer, and the block turns each direction's internal serial clock into single-cycle strobes. Receive data and frame syncs are taken on the falling edge of the internal clock. Transmit data is launched on the rising edge of the internal transmit clock. A global-sync control forces the receive frame sync to be an input. A loopback control feeds the transmit clock, frame sync and data into the receive side in place of the receive pins.

Top module: `serial_clkfs_select`

## Requirements
- R1: With `mode_rx_clk`/`mode_tx_clk` at 1, that direction's internal clock follows `gen_clk_i`, and the clock pin output enable is 1. At 0, the internal clock follows the synchronized clock pin, the output enable is 0, and `gen_clk_i` has no effect. Each direction selects independently.
- R2: A clock polarity bit of 1 inverts the pin level before it forms the internal clock, and inverts `gen_clk_i` onto the clock pin output. The generator-sourced internal clock itself is never inverted.
- R3: With a frame mode bit at 1, the frame sync pin output enable is 1, the pin output is `gen_fs_i` XOR the frame polarity bit, and the active-high internal sync (`*_fs_act`) equals `gen_fs_i`. At 0, the output enable is 0.
- R4: With a frame mode bit at 0, the internal sync equals the synchronized pin level XOR the frame polarity bit.
- R5: With `global_sync` at 1, the receive frame sync pin is an input (output enable 0) and `rx_fs_act` comes from the pin XOR polarity, even when `mode_rx_fs` is 1. The transmit side is unaffected.
- R6: On each falling edge of the internal receive clock, `rx_sample_stb` pulses for one cycle and `rx_bit_o` takes the receive data level. `rx_bit_o` holds between samples.
- R7: On each rising edge of the internal transmit clock, `tx_launch_stb` pulses for one cycle and `tx_data_pin_o` takes `tx_bit_i`. At all other times `tx_data_pin_o` holds its value.
- R8: `rx_frame_stb` / `tx_frame_stb` pulse on a falling edge of that direction's internal clock exactly when its internal frame sync is high.
- R9: With `loopback` at 1, the receive side uses the transmit internal clock, the transmit internal frame sync and `tx_data_pin_o`. The receive clock, frame and data pins are ignored.
- R10: A change on a pin input produces its strobe in the third system cycle, because it passes two synchronizer stages. A change on `gen_clk_i` produces its strobe after one system edge. Mode and polarity inputs take effect after one system edge.
- R11: After reset all strobes, output enables, `tx_data_pin_o` and `rx_bit_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_rx_clk | input | 1 | Receive clock from generator (1) or pin (0) |
| mode_tx_clk | input | 1 | Transmit clock from generator (1) or pin (0) |
| mode_rx_fs | input | 1 | Receive frame sync driven from generator (1) or pin input (0) |
| mode_tx_fs | input | 1 | Transmit frame sync driven from generator (1) or pin input (0) |
| pol_rx_clk | input | 1 | Receive clock pin inversion |
| pol_tx_clk | input | 1 | Transmit clock pin inversion |
| pol_rx_fs | input | 1 | Receive frame pin inversion |
| pol_tx_fs | input | 1 | Transmit frame pin inversion |
| global_sync | input | 1 | Forces receive frame sync to be a pin input |
| loopback | input | 1 | Feeds transmit clock, sync and data to receive |
| gen_clk_i | input | 1 | Sample-rate generator clock level |
| gen_fs_i | input | 1 | Sample-rate generator frame sync (active high) |
| rx_clk_pin_i | input | 1 | Receive clock pin input |
| rx_clk_pin_o | output | 1 | Receive clock pin output value |
| rx_clk_pin_oe | output | 1 | Receive clock pin output enable |
| tx_clk_pin_i | input | 1 | Transmit clock pin input |
| tx_clk_pin_o | output | 1 | Transmit clock pin output value |
| tx_clk_pin_oe | output | 1 | Transmit clock pin output enable |
| rx_fs_pin_i | input | 1 | Receive frame pin input |
| rx_fs_pin_o | output | 1 | Receive frame pin output value |
| rx_fs_pin_oe | output | 1 | Receive frame pin output enable |
| tx_fs_pin_i | input | 1 | Transmit frame pin input |
| tx_fs_pin_o | output | 1 | Transmit frame pin output value |
| tx_fs_pin_oe | output | 1 | Transmit frame pin output enable |
| rx_data_pin_i | input | 1 | Receive serial data pin |
| tx_data_pin_o | output | 1 | Transmit serial data pin |
| tx_bit_i | input | 1 | Next transmit bit from the shift logic |
| rx_fs_act | output | 1 | Active-high internal receive frame sync |
| tx_fs_act | output | 1 | Active-high internal transmit frame sync |
| rx_sample_stb | output | 1 | One-cycle pulse: receive bit sampled |
| rx_bit_o | output | 1 | Last sampled receive bit |
| rx_frame_stb | output | 1 | One-cycle pulse: receive frame sync seen |
| tx_launch_stb | output | 1 | One-cycle pulse: transmit bit launched |
| tx_frame_stb | output | 1 | One-cycle pulse: transmit frame sync seen |

## Verification
The clock path is swept over every combination of source mode, polarity and data level. In each case the selected source and the unselected source are toggled in turn, and the strobes are counted after each half period. Inversion shows up as a strobe appearing after the rising half rather than the falling one, and a wrong selection shows up as strobes from the unselected source. The frame path is swept over mode, polarity and level, with the pin and the generator driven to opposite levels so that the chosen source can be told apart. Global sync and loopback are tried with the ignored pins driven against the expected result. Single-cycle latency probes separate the two-stage synchronized pin path from the direct generator path and from the registered configuration.

// File: rtl/serport_sel_pkg.sv
// Shared types for the serial port clock/frame selector.
package serport_sel_pkg;

    // Per-direction source and polarity controls, registered in the top.
    typedef struct packed {
        logic clk_int;   // 1: clock from generator, 0: from pin
        logic fs_int;    // 1: frame sync driven from generator
        logic clk_pol;   // invert clock pin path
        logic fs_pol;    // invert frame pin path
    } dir_cfg_t;

endpackage

// File: rtl/sp_pin_sync.sv
// Multi-stage level synchronizer for asynchronous pin inputs.
// Assumes the inputs are slow levels compared with clk; each bit is handled
// independently, so no coherency between bits is implied.
module sp_pin_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the pin levels one stage further toward the system domain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d_i;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sp_dir_select.sv
// Source multiplexers and polarity XORs for one direction (clock and frame).
// Assumes pin inputs are already synchronized. A loopback path, when enabled,
// replaces both internal signals; fs_out_allow lets the caller veto
// internal frame driving (used for global sync on the receive side).
module sp_dir_select
    import serport_sel_pkg::*;
(
    input  dir_cfg_t cfg,
    input  logic     fs_out_allow,
    input  logic     clk_pin_s,
    input  logic     fs_pin_s,
    input  logic     gen_clk,
    input  logic     gen_fs,
    input  logic     lb_en,
    input  logic     lb_clk,
    input  logic     lb_fs,
    output logic     int_clk,
    output logic     int_fs,
    output logic     clk_pin_o,
    output logic     clk_oe,
    output logic     fs_pin_o,
    output logic     fs_oe
);
    logic fs_drive;

    // Pick the internal clock and active-high frame sync for this direction.
    always_comb begin
        fs_drive = cfg.fs_int & fs_out_allow;
        if (lb_en) begin
            int_clk = lb_clk;
            int_fs  = lb_fs;
        end else begin
            int_clk = cfg.clk_int ? gen_clk : (clk_pin_s ^ cfg.clk_pol);
            int_fs  = fs_drive    ? gen_fs  : (fs_pin_s  ^ cfg.fs_pol);
        end
    end

    // Pin outputs carry the generator signals through the polarity XOR.
    always_comb begin
        clk_pin_o = gen_clk ^ cfg.clk_pol;
        clk_oe    = cfg.clk_int;
        fs_pin_o  = gen_fs ^ cfg.fs_pol;
        fs_oe     = fs_drive;
    end
endmodule

// File: rtl/sp_edge_unit.sv
// Edge detector and bit/frame strobes for one direction.
// Assumes int_clk is a level sampled on clk. Frame syncs are taken on the
// falling edge; the data bit is captured on the falling edge or launched on
// the rising edge, chosen by LAUNCH_ON_RISE.
module sp_edge_unit #(
    parameter bit LAUNCH_ON_RISE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_clk,
    input  logic int_fs,
    input  logic data_in,
    output logic bit_stb,
    output logic frame_stb,
    output logic bit_q
);
    logic clk_q;
    logic rise;
    logic fall;

    assign rise = int_clk & ~clk_q;
    assign fall = ~int_clk & clk_q;

    // Remember the previous internal clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_q <= 1'b0;
        else clk_q <= int_clk;
    end

    // Frame sync seen on the falling edge while active.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_stb <= 1'b0;
        else frame_stb <= fall & int_fs;
    end

    generate
        if (LAUNCH_ON_RISE) begin : g_launch
            // Launch the next bit on the rising edge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bit_stb <= 1'b0;
                    bit_q   <= 1'b0;
                end else begin
                    bit_stb <= rise;
                    if (rise) bit_q <= data_in;
                end
            end
        end else begin : g_capture
            // Capture the incoming bit on the falling edge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bit_stb <= 1'b0;
                    bit_q   <= 1'b0;
                end else begin
                    bit_stb <= fall;
                    if (fall) bit_q <= data_in;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/serial_clkfs_select.sv
// Top of the serial port clock and frame selector.
// Registers the controls, synchronizes the pins, selects sources per
// direction and derives strobes. Single system clock domain; serial clocks
// are sampled levels that must be well below clk/4.
module serial_clkfs_select
    import serport_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_rx_clk,
    input  logic mode_tx_clk,
    input  logic mode_rx_fs,
    input  logic mode_tx_fs,
    input  logic pol_rx_clk,
    input  logic pol_tx_clk,
    input  logic pol_rx_fs,
    input  logic pol_tx_fs,
    input  logic global_sync,
    input  logic loopback,
    input  logic gen_clk_i,
    input  logic gen_fs_i,
    input  logic rx_clk_pin_i,
    output logic rx_clk_pin_o,
    output logic rx_clk_pin_oe,
    input  logic tx_clk_pin_i,
    output logic tx_clk_pin_o,
    output logic tx_clk_pin_oe,
    input  logic rx_fs_pin_i,
    output logic rx_fs_pin_o,
    output logic rx_fs_pin_oe,
    input  logic tx_fs_pin_i,
    output logic tx_fs_pin_o,
    output logic tx_fs_pin_oe,
    input  logic rx_data_pin_i,
    output logic tx_data_pin_o,
    input  logic tx_bit_i,
    output logic rx_fs_act,
    output logic tx_fs_act,
    output logic rx_sample_stb,
    output logic rx_bit_o,
    output logic rx_frame_stb,
    output logic tx_launch_stb,
    output logic tx_frame_stb
);
    localparam int NPINS = 5;

    dir_cfg_t rx_cfg_q, tx_cfg_q;
    logic     gsync_q, lb_q;
    logic [NPINS-1:0] pins_raw, pins_s;
    logic rx_int_clk, tx_int_clk, rx_int_fs, tx_int_fs;
    logic rx_data_sel;

    // Controls take effect one system clock after they change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cfg_q <= '0;
            tx_cfg_q <= '0;
            gsync_q  <= 1'b0;
            lb_q     <= 1'b0;
        end else begin
            rx_cfg_q <= '{clk_int: mode_rx_clk, fs_int: mode_rx_fs,
                          clk_pol: pol_rx_clk,  fs_pol: pol_rx_fs};
            tx_cfg_q <= '{clk_int: mode_tx_clk, fs_int: mode_tx_fs,
                          clk_pol: pol_tx_clk,  fs_pol: pol_tx_fs};
            gsync_q  <= global_sync;
            lb_q     <= loopback;
        end
    end

    assign pins_raw = {rx_data_pin_i, tx_fs_pin_i, rx_fs_pin_i,
                       tx_clk_pin_i, rx_clk_pin_i};

    sp_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pins_raw), .q_o(pins_s)
    );

    sp_dir_select u_tx_sel (
        .cfg(tx_cfg_q), .fs_out_allow(1'b1),
        .clk_pin_s(pins_s[1]), .fs_pin_s(pins_s[3]),
        .gen_clk(gen_clk_i), .gen_fs(gen_fs_i),
        .lb_en(1'b0), .lb_clk(1'b0), .lb_fs(1'b0),
        .int_clk(tx_int_clk), .int_fs(tx_int_fs),
        .clk_pin_o(tx_clk_pin_o), .clk_oe(tx_clk_pin_oe),
        .fs_pin_o(tx_fs_pin_o), .fs_oe(tx_fs_pin_oe)
    );

    sp_dir_select u_rx_sel (
        .cfg(rx_cfg_q), .fs_out_allow(~gsync_q),
        .clk_pin_s(pins_s[0]), .fs_pin_s(pins_s[2]),
        .gen_clk(gen_clk_i), .gen_fs(gen_fs_i),
        .lb_en(lb_q), .lb_clk(tx_int_clk), .lb_fs(tx_int_fs),
        .int_clk(rx_int_clk), .int_fs(rx_int_fs),
        .clk_pin_o(rx_clk_pin_o), .clk_oe(rx_clk_pin_oe),
        .fs_pin_o(rx_fs_pin_o), .fs_oe(rx_fs_pin_oe)
    );

    assign rx_data_sel = lb_q ? tx_data_pin_o : pins_s[4];
    assign rx_fs_act   = rx_int_fs;
    assign tx_fs_act   = tx_int_fs;

    sp_edge_unit #(.LAUNCH_ON_RISE(1'b1)) u_tx_edge (
        .clk(clk), .rst_n(rst_n), .int_clk(tx_int_clk), .int_fs(tx_int_fs),
        .data_in(tx_bit_i), .bit_stb(tx_launch_stb),
        .frame_stb(tx_frame_stb), .bit_q(tx_data_pin_o)
    );

    sp_edge_unit #(.LAUNCH_ON_RISE(1'b0)) u_rx_edge (
        .clk(clk), .rst_n(rst_n), .int_clk(rx_int_clk), .int_fs(rx_int_fs),
        .data_in(rx_data_sel), .bit_stb(rx_sample_stb),
        .frame_stb(rx_frame_stb), .bit_q(rx_bit_o)
    );
endmodule

// File: rtl/sp_select_checker.sv
// Protocol checks for serial_clkfs_select, attached by bind.
// Assumes synchronous active-low reset; all checks are disabled in reset.
module sp_select_checker (
    input logic clk,
    input logic rst_n,
    input logic mode_tx_clk,
    input logic mode_tx_fs,
    input logic global_sync,
    input logic tx_clk_pin_oe,
    input logic tx_fs_pin_oe,
    input logic rx_fs_pin_oe,
    input logic rx_sample_stb,
    input logic rx_frame_stb,
    input logic tx_launch_stb,
    input logic tx_frame_stb,
    input logic tx_data_pin_o
);
    p_clk_oe_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_tx_clk |=> tx_clk_pin_oe);
    p_clk_oe_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_tx_clk |=> !tx_clk_pin_oe);
    p_fs_oe_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_tx_fs |=> tx_fs_pin_oe);
    p_fs_oe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_tx_fs |=> !tx_fs_pin_oe);
    p_gsync_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
        global_sync |=> !rx_fs_pin_oe);
    p_sample_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sample_stb |=> !rx_sample_stb);
    p_launch_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_launch_stb |=> !tx_launch_stb);
    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_launch_stb |-> $stable(tx_data_pin_o));
    p_rx_frame_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_stb |-> rx_sample_stb);
    p_tx_frame_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame_stb |-> !tx_launch_stb);
endmodule

bind serial_clkfs_select sp_select_checker u_checker (
    .clk(clk), .rst_n(rst_n),
    .mode_tx_clk(mode_tx_clk), .mode_tx_fs(mode_tx_fs),
    .global_sync(global_sync),
    .tx_clk_pin_oe(tx_clk_pin_oe), .tx_fs_pin_oe(tx_fs_pin_oe),
    .rx_fs_pin_oe(rx_fs_pin_oe),
    .rx_sample_stb(rx_sample_stb), .rx_frame_stb(rx_frame_stb),
    .tx_launch_stb(tx_launch_stb), .tx_frame_stb(tx_frame_stb),
    .tx_data_pin_o(tx_data_pin_o)
);

// File: tb/tb_serial_clkfs_select.sv
// Self-checking bench: sweeps source/polarity/level combinations.
module tb_serial_clkfs_select;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_rx_clk = 0, mode_tx_clk = 0, mode_rx_fs = 0, mode_tx_fs = 0;
    logic pol_rx_clk = 0, pol_tx_clk = 0, pol_rx_fs = 0, pol_tx_fs = 0;
    logic global_sync = 0, loopback = 0;
    logic gen_clk_i = 0, gen_fs_i = 0;
    logic rx_clk_pin_i = 0, tx_clk_pin_i = 0, rx_fs_pin_i = 0, tx_fs_pin_i = 0;
    logic rx_data_pin_i = 0, tx_bit_i = 0;
    logic rx_clk_pin_o, rx_clk_pin_oe, tx_clk_pin_o, tx_clk_pin_oe;
    logic rx_fs_pin_o, rx_fs_pin_oe, tx_fs_pin_o, tx_fs_pin_oe;
    logic tx_data_pin_o, rx_fs_act, tx_fs_act;
    logic rx_sample_stb, rx_bit_o, rx_frame_stb, tx_launch_stb, tx_frame_stb;

    int n_tests = 0;
    int n_fail  = 0;
    int cnt_rs = 0, cnt_rf = 0, cnt_tl = 0, cnt_tf = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    serial_clkfs_select dut (.*);

    // Strobe counters, read on the rising edge before the design updates.
    always @(posedge clk) begin
        if (rx_sample_stb) cnt_rs <= cnt_rs + 1;
        if (rx_frame_stb)  cnt_rf <= cnt_rf + 1;
        if (tx_launch_stb) cnt_tl <= cnt_tl + 1;
        if (tx_frame_stb)  cnt_tf <= cnt_tf + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        tick(4);
        // R11: reset state
        check("R11 oe", {rx_clk_pin_oe, tx_clk_pin_oe, rx_fs_pin_oe, tx_fs_pin_oe}, 0);
        check("R11 strobes", {rx_sample_stb, rx_frame_stb, tx_launch_stb, tx_frame_stb}, 0);
        check("R11 data", {tx_data_pin_o, rx_bit_o}, 0);
        rst_n = 1'b1;
        tick(4);

        // R10: control change lands after one edge
        mode_tx_clk = 1;
        #1 check("R10 cfg before edge", tx_clk_pin_oe, 0);
        tick(1);
        check("R10 cfg after edge", tx_clk_pin_oe, 1);
        mode_tx_clk = 0;
        tick(4);

        // R1 R2 R6: receive clock sweep
        for (int m = 0; m < 2; m++)
            for (int p = 0; p < 2; p++)
                for (int d = 0; d < 2; d++) begin
                    mode_rx_clk = m[0]; pol_rx_clk = p[0]; rx_data_pin_i = d[0];
                    gen_clk_i = 0; rx_clk_pin_i = 0;
                    tick(8);
                    base = cnt_rs;
                    if (m) begin rx_clk_pin_i = 1; tick(6); rx_clk_pin_i = 0; end
                    else begin gen_clk_i = 1; tick(6); gen_clk_i = 0; end
                    tick(6);
                    check("R1 rx unselected ignored", cnt_rs - base, 0);
                    if (m) gen_clk_i = 1; else rx_clk_pin_i = 1;
                    tick(8);
                    check("R2 rx half period", cnt_rs - base, (m == 0 && p == 1) ? 1 : 0);
                    if (m) gen_clk_i = 0; else rx_clk_pin_i = 0;
                    tick(8);
                    check("R1 rx full period", cnt_rs - base, 1);
                    check("R6 rx bit", rx_bit_o, d);
                    check("R1 rx clk oe", rx_clk_pin_oe, m);
                    if (m) check("R2 rx clk pin out", rx_clk_pin_o, p);
                end

        // R1 R2 R7: transmit clock sweep
        for (int m = 0; m < 2; m++)
            for (int p = 0; p < 2; p++)
                for (int d = 0; d < 2; d++) begin
                    mode_tx_clk = m[0]; pol_tx_clk = p[0]; tx_bit_i = d[0];
                    gen_clk_i = 0; tx_clk_pin_i = 0;
                    tick(8);
                    base = cnt_tl;
                    if (m) gen_clk_i = 1; else tx_clk_pin_i = 1;
                    tick(8);
                    check("R2 tx half period", cnt_tl - base, (m == 0 && p == 1) ? 0 : 1);
                    if (m) gen_clk_i = 0; else tx_clk_pin_i = 0;
                    tick(8);
                    check("R1 tx full period", cnt_tl - base, 1);
                    check("R7 tx data launched", tx_data_pin_o, d);
                    tx_bit_i = ~d[0];
                    tick(5);
                    check("R7 tx data held", tx_data_pin_o, d);
                    check("R1 tx clk oe", tx_clk_pin_oe, m);
                    if (m) check("R2 tx clk pin out", tx_clk_pin_o, p);
                end

        // R3 R4 R8: frame sync sweep, pin and generator at opposite levels
        mode_rx_clk = 1; mode_tx_clk = 1; pol_rx_clk = 0; pol_tx_clk = 0;
        gen_clk_i = 0;
        for (int m = 0; m < 2; m++)
            for (int p = 0; p < 2; p++)
                for (int l = 0; l < 2; l++) begin
                    int exp_rx, exp_tx, rb, tb;
                    mode_rx_fs = m[0]; mode_tx_fs = ~m[0];
                    pol_rx_fs = p[0]; pol_tx_fs = p[0];
                    gen_fs_i = l[0]; rx_fs_pin_i = ~l[0]; tx_fs_pin_i = ~l[0];
                    tick(8);
                    exp_rx = m ? l : ((1 - l) ^ p);
                    exp_tx = m ? ((1 - l) ^ p) : l;
                    check(m ? "R3 rx fs act" : "R4 rx fs act", rx_fs_act, exp_rx);
                    check(m ? "R4 tx fs act" : "R3 tx fs act", tx_fs_act, exp_tx);
                    check("R3 rx fs oe", rx_fs_pin_oe, m);
                    check("R3 tx fs oe", tx_fs_pin_oe, 1 - m);
                    if (m) check("R3 rx fs pin out", rx_fs_pin_o, l ^ p);
                    else   check("R3 tx fs pin out", tx_fs_pin_o, l ^ p);
                    rb = cnt_rf; tb = cnt_tf;
                    gen_clk_i = 1; tick(6); gen_clk_i = 0; tick(6);
                    check("R8 rx frame strobes", cnt_rf - rb, exp_rx);
                    check("R8 tx frame strobes", cnt_tf - tb, exp_tx);
                end

        // R5: global sync keeps the receive frame pin an input
        for (int p = 0; p < 2; p++) begin
            mode_rx_fs = 1; mode_tx_fs = 1; global_sync = 1; pol_rx_fs = p[0];
            gen_fs_i = 1; rx_fs_pin_i = 0;
            tick(8);
            check("R5 rx fs oe", rx_fs_pin_oe, 0);
            check("R5 rx fs from pin", rx_fs_act, p);
            check("R5 tx unaffected", tx_fs_pin_oe, 1);
        end
        global_sync = 0; mode_rx_fs = 0; mode_tx_fs = 0; pol_rx_fs = 0;
        gen_fs_i = 0;
        tick(6);

        // R9: loopback
        loopback = 1; mode_tx_clk = 1; mode_rx_clk = 0; gen_clk_i = 0;
        rx_data_pin_i = 0; tx_bit_i = 1;
        tick(8);
        base = cnt_rs;
        rx_clk_pin_i = 1; tick(6); rx_clk_pin_i = 0; tick(6);
        check("R9 rx pin ignored", cnt_rs - base, 0);
        gen_clk_i = 1; tick(6); gen_clk_i = 0; tick(6);
        check("R9 rx clocked by tx", cnt_rs - base, 1);
        check("R9 rx data from tx", rx_bit_o, 1);
        mode_tx_fs = 1; gen_fs_i = 1; rx_fs_pin_i = 0;
        tick(6);
        check("R9 rx fs from tx", rx_fs_act, 1);
        loopback = 0; mode_tx_fs = 0; gen_fs_i = 0; tx_bit_i = 0;
        tick(6);

        // R10: strobe latency, generator path then pin path
        mode_rx_clk = 1; gen_clk_i = 1;
        tick(6);
        gen_clk_i = 0;
        tick(1);
        check("R10 gen strobe after one edge", rx_sample_stb, 1);
        tick(1);
        check("R10 gen strobe single", rx_sample_stb, 0);
        mode_rx_clk = 0; pol_rx_clk = 0; rx_clk_pin_i = 1;
        tick(8);
        rx_clk_pin_i = 0;
        tick(2);
        check("R10 pin strobe not before third edge", rx_sample_stb, 0);
        tick(1);
        check("R10 pin strobe at third edge", rx_sample_stb, 1);
        tick(2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule